// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block turns a host request into the serial byte frames that a NOR flash chip on a mode-0 serial bus expects. The host names an operation (read, page program or sector erase), a chip, a 24-bit byte address and a byte count, and pulses `start`. The block rejects any request that would fall outside the device. Otherwise it drives one chip-select low per frame, clocks opcode and address bytes out most significant bit first, and moves payload bytes over two valid/ready byte streams: write data in, read data out.

A program or erase opens the chip for writing with a separate one-byte frame first. The block remembers which chips have been given a write and does not wait for it to finish. The next request that targets such a chip starts with a run of status-read frames. These repeat until the write-in-progress bit of the status byte reads 0. Requests to a different chip skip the wait.

Top module: `nor_cmd_seq`

## Requirements
- R1: A request is rejected when the operation code is 3, when its start address is not below `CAP_BYTES`, when start plus span exceeds `CAP_BYTES` (the span is 65536 for an erase and `len` otherwise), when a read or program has `len` 0, or when a program's `addr % 256 + len` exceeds 256. A rejected request sets `done` and `err` one cycle after `start`, and no chip-select falls.
- R2: The main frame of an accepted request sends the opcode and then address bits 23:16, 15:8 and 7:0. The opcodes are 0x03 for read (operation 0), 0x02 for program (operation 1) and 0xD8 for erase (operation 2).
- R3: Before its main frame, a program or erase has a frame of its own that carries exactly one byte, 0x06.
- R4: Every write-enable frame marks its chip busy. The next request to a busy chip begins with 2-byte status frames, 0x05 followed by a received byte, repeated until bit 0 of that byte is 0, which clears the mark. A chip that is not marked gets no status frame.
- R5: A program main frame carries, after the address, exactly `len` bytes taken in order from the write stream. `wr_ready` is high only while the block waits for one of those bytes.
- R6: A read main frame clocks `len` bytes after the address with MOSI held at 0x00. Each byte received is offered on `rd_data` with `rd_valid`, in order, and is held until `rd_ready`.
- R7: An erase main frame is exactly 4 bytes long.
- R8: At most one chip-select is low at any time. Between two frames, all chip-selects stay high for at least 2 clock cycles, one SCLK period.
- R9: SCLK runs at half the clock rate and rests low, as in SPI mode 0. Bits are shifted most significant first, and the device's MISO is sampled on the rising SCLK edge.
- R10: After reset all chip-selects are high and `busy` and `done` are low. `busy` is high from the cycle after an accepted `start` until `done`. `done` lasts one cycle, and `err` is 0 after an accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| op | input | 2 | 0 read, 1 program, 2 erase, 3 invalid |
| chip | input | CHIP_W | Target chip index |
| addr | input | 24 | Byte address within the chip |
| len | input | 9 | Byte count for read or program |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |
| wr_data | input | 8 | Program data byte |
| wr_valid | input | 1 | Program data present |
| wr_ready | output | 1 | Program byte taken this cycle |
| rd_data | output | 8 | Read data byte |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Host takes read byte |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | NCHIP | Active-low chip-selects |

## Verification
A stale or missing busy mark shows at the ports on the very next request to that chip. Status frames then appear where none are due, or are missing before a read of a chip still writing, so the frame count of that request is wrong. A byte counter or frame selector that is off by one shows as a wrong frame length or a shifted address or data byte in the frame that follows. A wrong range decision shows within one cycle as a spurious `err` or as a chip-select that falls when it should not. Gap and chip-select mistakes show at the first frame boundary of any multi-frame request.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_SERA = 8'hD8;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  // opcode that opens the main frame of each operation
  function automatic logic [7:0] main_opcode(op_e op);
    case (op)
      OP_READ: main_opcode = OPC_READ;
      OP_PROG: main_opcode = OPC_PROG;
      default: main_opcode = OPC_SERA;
    endcase
  endfunction

  // range, length and page rule for a request
  function automatic logic req_ok(op_e op, logic [23:0] a, logic [8:0] n,
                                  logic [31:0] cap, logic [31:0] sect,
                                  logic [31:0] page);
    logic [31:0] a32;
    logic [31:0] span;
    logic [31:0] poff;
    a32  = {8'd0, a};
    span = (op == OP_ERASE) ? sect : {23'd0, n};
    poff = a32 & (page - 32'd1);
    req_ok = (op != OP_NONE) && (a32 < cap) && (a32 + span <= cap) &&
             ((op == OP_ERASE) || (n != 9'd0)) &&
             ((op != OP_PROG) || (poff + {23'd0, n} <= page));
  endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx,
  input  logic              miso,
  output logic              done,
  output logic [BYTE_W-1:0] rx,
  output logic              sclk,
  output logic              mosi,
  output logic              active
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; rx <= '0; cnt <= '0; ph <= 1'b0;
      active <= 1'b0; sclk <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        sh <= tx; cnt <= '0; ph <= 1'b0; active <= 1'b1;
      end else if (active) begin
        if (!ph) begin
          sclk <= 1'b1;
          rx   <= {rx[BYTE_W-2:0], miso};
          ph   <= 1'b1;
        end else begin
          sclk <= 1'b0;
          ph   <= 1'b0;
          sh   <= {sh[BYTE_W-2:0], 1'b0};
          if (cnt == CNT_W'(BYTE_W - 1)) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  assign mosi = sh[BYTE_W-1];

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active); // R9
  AST_CLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sclk); // R9

endmodule

// File: rtl/chip_busy_flags.sv
module chip_busy_flags #(
  parameter int NCHIP  = 2,
  parameter int CHIP_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [CHIP_W-1:0] idx,
  output logic [NCHIP-1:0]  flags
);
  for (genvar i = 0; i < NCHIP; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else if (set_en && idx == CHIP_W'(i))
        flags[i] <= 1'b1;
      else if (clr_en && idx == CHIP_W'(i))
        flags[i] <= 1'b0;
    end
  end

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en && clr_en)); // R4

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int          NCHIP        = 2,
  parameter logic [31:0] CAP_BYTES    = 32'h0004_0000,
  parameter logic [31:0] SECTOR_BYTES = 32'h0001_0000,
  parameter logic [31:0] PAGE_BYTES   = 32'd256,
  parameter int          GAP_CYC      = 2,
  localparam int         CHIP_W       = (NCHIP > 1) ? $clog2(NCHIP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [CHIP_W-1:0] chip,
  input  logic [23:0]       addr,
  input  logic [8:0]        len,
  output logic              busy,
  output logic              done,
  output logic              err,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NCHIP-1:0]  spi_cs_n
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_LOAD, S_SHIFT, S_RDOUT} st_e;
  typedef enum logic [1:0] {F_POLL, F_WREN, F_MAIN} fr_e;

  st_e               st;
  fr_e               fr;
  op_e               op_q;
  logic [CHIP_W-1:0] chip_q;
  logic [23:0]       addr_q;
  logic [8:0]        len_q;
  logic [9:0]        bi;
  logic [GAP_W-1:0]  gap;
  logic              cs_act;
  logic [7:0]        rd_q;
  logic [NCHIP-1:0]  flags;
  logic [9:0]        flen;
  logic [7:0]        tx_b;
  logic              eng_start, eng_done, eng_active;
  logic [7:0]        eng_rx;

  // named internal events
  wire req_good   = req_ok(op_e'(op), addr, len, CAP_BYTES, SECTOR_BYTES, PAGE_BYTES);
  wire frame_end  = (st == S_LOAD) && (bi == flen);
  wire poll_clear = frame_end && (fr == F_POLL) && !rd_q[0];
  wire wren_done  = frame_end && (fr == F_WREN);
  wire gap_exit   = (st == S_GAP) && (gap == '0);
  wire in_data    = (fr == F_MAIN) && (bi >= 10'd4);
  wire need_w     = (st == S_LOAD) && !frame_end && in_data && (op_q == OP_PROG);
  wire fr_e after_poll = (op_q == OP_READ) ? F_MAIN : F_WREN;

  always_comb begin
    case (fr)
      F_POLL:  flen = 10'd2;
      F_WREN:  flen = 10'd1;
      default: flen = (op_q == OP_ERASE) ? 10'd4 : 10'd4 + {1'b0, len_q};
    endcase
  end

  always_comb begin
    tx_b = 8'h00;
    if (bi == 10'd0) begin
      case (fr)
        F_POLL:  tx_b = OPC_RDSR;
        F_WREN:  tx_b = OPC_WREN;
        default: tx_b = main_opcode(op_q);
      endcase
    end else if (fr == F_MAIN && bi == 10'd1) tx_b = addr_q[23:16];
    else if (fr == F_MAIN && bi == 10'd2)     tx_b = addr_q[15:8];
    else if (fr == F_MAIN && bi == 10'd3)     tx_b = addr_q[7:0];
    else if (need_w)                          tx_b = wr_data;
  end

  assign eng_start = (st == S_LOAD) && !frame_end && (!need_w || wr_valid);
  assign wr_ready  = need_w;
  assign busy      = (st != S_IDLE);
  assign rd_valid  = (st == S_RDOUT);
  assign rd_data   = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; fr <= F_MAIN; op_q <= OP_READ; chip_q <= '0;
      addr_q <= '0; len_q <= '0; bi <= '0; gap <= '0; cs_act <= 1'b0;
      rd_q <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (req_good) begin
            op_q <= op_e'(op); chip_q <= chip; addr_q <= addr; len_q <= len;
            err  <= 1'b0;
            fr   <= flags[chip] ? F_POLL : ((op_e'(op) != OP_READ) ? F_WREN : F_MAIN);
            gap  <= GAP_W'(GAP_CYC - 1);
            st   <= S_GAP;
          end else begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        S_GAP: if (gap == '0) begin
          cs_act <= 1'b1; bi <= '0; st <= S_LOAD;
        end else begin
          gap <= gap - 1'b1;
        end
        S_LOAD: if (frame_end) begin
          cs_act <= 1'b0;
          gap    <= GAP_W'(GAP_CYC - 1);
          case (fr)
            F_POLL: begin fr <= rd_q[0] ? F_POLL : after_poll; st <= S_GAP; end
            F_WREN: begin fr <= F_MAIN; st <= S_GAP; end
            default: begin st <= S_IDLE; done <= 1'b1; end
          endcase
        end else if (eng_start) begin
          st <= S_SHIFT;
        end
        S_SHIFT: if (eng_done) begin
          rd_q <= eng_rx;
          bi   <= bi + 1'b1;
          st   <= (in_data && op_q == OP_READ) ? S_RDOUT : S_LOAD;
        end
        S_RDOUT: if (rd_ready) st <= S_LOAD;
        default: st <= S_IDLE;
      endcase
    end
  end

  spi_byte_engine #(.BYTE_W(8)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx(tx_b), .miso(spi_miso),
    .done(eng_done), .rx(eng_rx), .sclk(spi_sclk), .mosi(spi_mosi),
    .active(eng_active)
  );

  chip_busy_flags #(.NCHIP(NCHIP), .CHIP_W(CHIP_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_en(wren_done), .clr_en(poll_clear),
    .idx(chip_q), .flags(flags)
  );

  for (genvar i = 0; i < NCHIP; i++) begin : g_cs
    assign spi_cs_n[i] = !(cs_act && chip_q == CHIP_W'(i));
  end

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n)); // R8
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_act) |-> ($past(!cs_act) && $past(!cs_act, 2))); // R8
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start && !req_good) |=> (done && err && !cs_act)); // R1
  AST_WREN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_exit && fr == F_MAIN && op_q != OP_READ) |-> flags[chip_q]); // R3
  AST_POLL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_exit && fr == F_POLL) |-> flags[chip_q]); // R4
  AST_WR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (cs_act && !spi_sclk && !eng_active)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

// File: tb/nor_cmd_seq_bench.sv
module nor_cmd_seq_bench;
  localparam int CAP = 32'h40000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr_valid = 1'b0, rd_ready = 1'b1;
  logic [1:0] op = 2'd0;
  logic [0:0] chip = 1'b0;
  logic [23:0] addr = '0;
  logic [8:0] len = '0;
  logic [7:0] wr_data = '0;
  logic busy, done, err, wr_ready, rd_valid, spi_sclk, spi_mosi, spi_miso;
  logic [7:0] rd_data;
  logic [1:0] spi_cs_n;

  always #5 clk = ~clk;

  nor_cmd_seq u_nor_cmd_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .chip(chip), .addr(addr),
    .len(len), .busy(busy), .done(done), .err(err), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int nchk = 0, nfail = 0;

  function automatic logic [7:0] rdpat(logic [23:0] a, int ch);
    return 8'(a * 29) ^ a[15:8] ^ 8'(ch * 90);
  endfunction
  function automatic logic [7:0] wpat(int i, int seed);
    return 8'(i * 37 + seed);
  endfunction

  // flash model: frame capture and status / read responses
  wire cs_any = ~&spi_cs_n;
  logic [7:0] fb [0:263];
  logic [7:0] cur = '0;
  int nb = 0, bc = 0, fch = 0, fcount = 0;
  int wip_left [0:1] = '{0, 0};
  logic [7:0] lop [0:15];
  int llen [0:15];
  int lch [0:15];
  int gapa [0:15];

  always @(posedge spi_sclk or negedge cs_any) begin
    if (rst_n) begin
      if (!cs_any) begin
        lop[fcount & 15] = fb[0];
        llen[fcount & 15] = nb;
        lch[fcount & 15] = fch;
        if (fb[0] == 8'h05 && wip_left[fch] > 0) wip_left[fch] = wip_left[fch] - 1;
        if (fb[0] == 8'h02 || fb[0] == 8'hD8) wip_left[fch] = 3;
        fcount = fcount + 1;
        nb = 0; bc = 0;
      end else begin
        fch = spi_cs_n[0] ? 1 : 0;
        cur = {cur[6:0], spi_mosi};
        bc = bc + 1;
        if (bc == 8) begin
          if (nb < 264) fb[nb] = cur;
          nb = nb + 1; bc = 0;
        end
      end
    end
  end

  logic [7:0] obyte;
  always @* begin
    obyte = 8'h00;
    if (nb == 1 && fb[0] == 8'h05) obyte = {7'd0, wip_left[fch] != 0};
    else if (nb >= 4 && fb[0] == 8'h03)
      obyte = rdpat({fb[1], fb[2], fb[3]} + 24'(nb - 4), fch);
  end
  assign spi_miso = obyte[3'(7 - bc)];

  int hi_cnt = 0;
  always @(negedge clk) begin
    if (cs_any) begin
      if (hi_cnt != 0) gapa[fcount & 15] = hi_cnt;
      hi_cnt = 0;
    end else hi_cnt = hi_cnt + 1;
  end

  logic [7:0] rdbuf [0:511];
  int rcount = 0;
  always @(negedge clk) begin
    if (rd_valid && rd_ready) begin
      rdbuf[rcount & 511] = rd_data;
      rcount = rcount + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  bit exp_busy [0:1] = '{0, 0};

  task automatic run(int o, int ch, int a, int n, int seed);
    int span, np, nw, tot, f0, r0, k, moff;
    bit ok;
    span = (o == 2) ? 65536 : n;
    ok = (o < 3) && (a < CAP) && (a + span <= CAP) && (o == 2 || n > 0) &&
         (o != 1 || (a % 256) + n <= 256);
    f0 = fcount; r0 = rcount;
    fork
      begin
        if (ok && o == 1) begin
          int i;
          bit t;
          i = 0; wr_valid = 1'b1; wr_data = wpat(0, seed);
          while (i < n) begin
            t = wr_ready;
            @(negedge clk);
            if (t) begin i++; wr_data = wpat(i, seed); end
          end
          wr_valid = 1'b0;
        end
      end
      begin
        start = 1'b1; op = 2'(o); chip = 1'(ch); addr = 24'(a); len = 9'(n);
        @(negedge clk);
        start = 1'b0;
        if (ok) chk("R10 busy after accept", busy, 1);
        else chk("R1 reject done", done, 1);
        k = 0;
        while (!done && k < 30000) begin @(negedge clk); k++; end
      end
    join
    chk("R10 done seen", done, 1);
    chk(ok ? "R10 err clear" : "R1 err set", err, ok ? 0 : 1);
    if (!ok) begin
      chk("R1 no frames", fcount - f0, 0);
    end else begin
      np = exp_busy[ch] ? 4 : 0;
      nw = (o != 0) ? 1 : 0;
      tot = np + nw + 1;
      chk("R4 R3 frame count", fcount - f0, tot);
      if (fcount - f0 == tot) begin
        for (int f = 0; f < tot; f++) begin
          int ix = (f0 + f) & 15;
          chk("R8 chip select", lch[ix], ch);
          if (f > 0) chk("R8 gap ok", int'(gapa[ix] >= 2), 1);
          if (f < np) begin
            chk("R4 poll opcode", lop[ix], 8'h05);
            chk("R4 poll length", llen[ix], 2);
          end else if (f < np + nw) begin
            chk("R3 wren opcode", lop[ix], 8'h06);
            chk("R3 wren length", llen[ix], 1);
          end else begin
            chk("R2 main opcode", lop[ix], (o == 0) ? 8'h03 : (o == 1) ? 8'h02 : 8'hD8);
            chk(o == 2 ? "R7 erase length" : "R5 R6 main length", llen[ix], (o == 2) ? 4 : 4 + n);
          end
        end
        chk("R2 address bytes", {fb[1], fb[2], fb[3]}, a);
        moff = 0;
        for (int i = 0; i < n && o != 2; i++) begin
          if (o == 1 && fb[4 + i] != wpat(i, seed)) moff++;
          if (o == 0 && (fb[4 + i] != 8'h00 || rdbuf[(r0 + i) & 511] != rdpat(24'(a + i), ch))) moff++;
        end
        if (o == 1) chk("R5 program data", moff, 0);
        if (o == 0) begin
          chk("R6 read count", rcount - r0, n);
          chk("R6 read data and zero MOSI", moff, 0);
        end
      end
      exp_busy[ch] = (o != 0);
    end
    @(negedge clk);
    chk("R9 sclk rests low", spi_sclk, 0);
    chk("R8 selects idle", spi_cs_n, 2'b11);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int addrs [0:5];
    int lens [0:4];
    int cnt;
    addrs = '{0, 'h1F8, 'h30000, 'h3FFF8, 'h3FFFF, 'h40000};
    lens = '{0, 1, 8, 200, 257};
    repeat (3) @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset selects", spi_cs_n, 2'b11);
    chk("R9 reset sclk", spi_sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: lazy polling per chip
    run(1, 0, 'h100, 4, 3);
    run(0, 1, 'h20, 2, 0);
    run(0, 0, 'h100, 3, 0);
    run(0, 0, 'h100, 3, 0);
    run(2, 1, 'h10000, 0, 0);
    run(1, 1, 'h10080, 128, 9);
    run(0, 1, 'h10080, 6, 0);
    // sweep over operations, boundary addresses and lengths
    cnt = 0;
    for (int o = 0; o < 4; o++)
      for (int ai = 0; ai < 6; ai++)
        for (int li = 0; li < 5; li++) begin
          run(o, cnt & 1, addrs[ai], lens[li], cnt);
          cnt++;
        end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule